// File: doc/BRIEF.md
# Serial Receive Word Packer with Idle-Line End Detection

This block sits behind a bit-recovery front end and turns a serial bit stream into 32-bit words for a receive FIFO. The front end presents one data bit on `rx_line` together with a single-cycle `bit_en` strobe per bit period. While `rx_en` is high, the block waits for the first bit that differs from the idle line level (logic 1). That bit is the least significant bit of the first byte. From then on every strobed bit is shifted in, least significant bit first. Each completed byte is counted and placed in the next byte lane of a word, and a full word is written to the FIFO port.

A message ends when the line has been at the idle level for eight consecutive bit periods. At that point the word that is still being filled is flushed to the FIFO with its empty lanes at zero. The running byte total is copied into a count register, the running counter restarts from zero, and a sticky done flag is raised. Software reads the count and clears the flag with `done_clr`. Dropping `rx_en` abandons any message in progress.

Top module: `serial_rx_packer`

## Requirements
- R1: Each completed byte of a message adds one to an internal 16-bit byte counter, and the count register receives its value when the message ends.
- R2: Every fourth byte of a message produces exactly one FIFO write. `fifo_wr` is high for one cycle, in the cycle after the clock edge that samples the byte's last bit.
- R3: Bits are assembled least significant bit first. Within a word, byte k of the message (counting from 0 within the word) occupies bits 8k+7:8k.
- R4: The idle line level is 1. A message ends on the eighth consecutive strobed 1 bit. Bits sampled after the last completed byte, including that eighth bit, are discarded. Seven consecutive 1 bits do not end a message. Payload must not contain eight consecutive 1 bits.
- R5: On the clock edge that samples the ending bit, the count register takes the message's byte count, the running counter clears, and `rx_done` goes high. All three outputs are visible in the next cycle.
- R6: If one to three bytes of the final word are pending when the message ends, that word is written to the FIFO in the same cycle as R5's updates. No write occurs when no byte is pending.
- R7: The byte lanes of a flushed partial word that received no byte are zero.
- R8: While waiting for a message, 1 bits and cycles without `bit_en` are ignored. The first strobed 0 bit is bit 0 of the first byte.
- R9: `rx_done` stays high until `done_clr` is pulsed. Clearing it leaves `byte_count` unchanged. If a message ends in the same cycle as a clear, `rx_done` ends up high.
- R10: While `rx_en` is low, the line is ignored. Any message in progress is dropped without a FIFO write, without setting `rx_done`, and without changing `byte_count`. The running counter restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_en | input | 1 | Receiver enable; low aborts and holds the receiver idle |
| bit_en | input | 1 | One-cycle strobe marking a valid bit on `rx_line` |
| rx_line | input | 1 | Serial data bit, idle level 1 |
| done_clr | input | 1 | One-cycle clear of `rx_done` |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 32 | Packed word, first byte in bits 7:0 |
| byte_count | output | 16 | Byte count of the last completed message |
| rx_done | output | 1 | Sticky message-complete flag |

## Verification
On every cycle, the in-line assertions check that the counter steps by one for each byte and that the idle run never reaches its limit unnoticed. They also check that a message end latches the count, clears the counter and sets the flag, that a pending partial word is flushed with zero upper lanes, and that the done flag is sticky. Only the bench's scenarios can show the actual byte lane order and bit order, and the number of words per message across lengths from one to twelve bytes and different strobe spacings. The same holds for the seven-ones-do-not-end case, the clear-versus-end collision, and the effect of an abort on the following message.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
  typedef enum logic {
    RX_WAIT = 1'b0,
    RX_BUSY = 1'b1
  } rx_state_e;
endpackage

// File: rtl/rxp_bit_shifter.sv
module rxp_bit_shifter
  import rxp_pkg::*;
#(
  parameter int   BYTE_BITS  = 8,
  parameter int   IDLE_BITS  = 8,
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_en,
  input  logic                 bit_en,
  input  logic                 rx_line,
  output logic                 byte_stb,
  output logic [BYTE_BITS-1:0] byte_val,
  output logic                 frame_end
);
  localparam int BIT_W  = $clog2(BYTE_BITS);
  localparam int IDLE_W = $clog2(IDLE_BITS + 1);

  rx_state_e          state_q, state_d;
  logic [BIT_W-1:0]     bit_cnt_q, bit_cnt_d;
  logic [IDLE_W-1:0]    run_q, run_d;
  logic [BYTE_BITS-1:0] shreg_q, shreg_d;

  logic take, is_idle, last_bit, busy;

  always_comb begin
    take      = bit_en && rx_en;
    is_idle   = (rx_line == IDLE_LEVEL);
    busy      = (state_q == RX_BUSY);
    last_bit  = (bit_cnt_q == BIT_W'(BYTE_BITS - 1));
    frame_end = take && busy && is_idle && (run_q == IDLE_W'(IDLE_BITS - 1));
    byte_val  = {rx_line, shreg_q[BYTE_BITS-1:1]};
    byte_stb  = take && busy && last_bit && !frame_end;
  end

  always_comb begin
    state_d   = state_q;
    bit_cnt_d = bit_cnt_q;
    run_d     = run_q;
    shreg_d   = shreg_q;
    if (!rx_en) begin
      state_d   = RX_WAIT;
      bit_cnt_d = '0;
      run_d     = '0;
      shreg_d   = '0;
    end else if (bit_en) begin
      if (!busy) begin
        if (!is_idle) begin
          state_d   = RX_BUSY;
          shreg_d   = {rx_line, {(BYTE_BITS-1){1'b0}}};
          bit_cnt_d = BIT_W'(1);
          run_d     = '0;
        end
      end else if (frame_end) begin
        state_d   = RX_WAIT;
        bit_cnt_d = '0;
        run_d     = '0;
        shreg_d   = '0;
      end else begin
        shreg_d   = byte_val;
        bit_cnt_d = last_bit ? '0 : bit_cnt_q + BIT_W'(1);
        run_d     = is_idle ? run_q + IDLE_W'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= RX_WAIT;
      bit_cnt_q <= '0;
      run_q     <= '0;
      shreg_q   <= '0;
    end else begin
      state_q   <= state_d;
      bit_cnt_q <= bit_cnt_d;
      run_q     <= run_d;
      shreg_q   <= shreg_d;
    end
  end

  // R4: the idle run is always caught before it reaches the limit
  assert_idle_run_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_q < IDLE_W'(IDLE_BITS));

  // R8: an idle-level bit while waiting does not start a message
  assert_wait_on_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_WAIT && rx_en && bit_en && rx_line == IDLE_LEVEL) |=> state_q == RX_WAIT);

  // R10: disabled receiver returns to waiting
  assert_disable_waits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> state_q == RX_WAIT);
endmodule

// File: rtl/rxp_word_packer.sv
module rxp_word_packer #(
  parameter int BYTE_BITS  = 8,
  parameter int WORD_BYTES = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            rx_en,
  input  logic                            byte_stb,
  input  logic [BYTE_BITS-1:0]            byte_val,
  input  logic                            frame_end,
  output logic                            fifo_wr,
  output logic [BYTE_BITS*WORD_BYTES-1:0] fifo_data
);
  localparam int WORD_W = BYTE_BITS * WORD_BYTES;
  localparam int LANE_W = $clog2(WORD_BYTES);

  logic [WORD_W-1:0] acc_q, acc_d, acc_fill;
  logic [LANE_W-1:0] lane_q, lane_d;
  logic              wr_q, wr_d;
  logic [WORD_W-1:0] data_q, data_d;
  logic              word_full, flush;

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    always_comb begin
      if (byte_stb && lane_q == LANE_W'(g))
        acc_fill[g*BYTE_BITS +: BYTE_BITS] = byte_val;
      else
        acc_fill[g*BYTE_BITS +: BYTE_BITS] = acc_q[g*BYTE_BITS +: BYTE_BITS];
    end
  end

  always_comb begin
    word_full = byte_stb && (lane_q == LANE_W'(WORD_BYTES - 1));
    flush     = frame_end && (lane_q != '0);
  end

  always_comb begin
    acc_d  = acc_q;
    lane_d = lane_q;
    wr_d   = 1'b0;
    data_d = data_q;
    if (!rx_en) begin
      acc_d  = '0;
      lane_d = '0;
    end else if (word_full) begin
      wr_d   = 1'b1;
      data_d = acc_fill;
      acc_d  = '0;
      lane_d = '0;
    end else if (byte_stb) begin
      acc_d  = acc_fill;
      lane_d = lane_q + LANE_W'(1);
    end else if (flush) begin
      wr_d   = 1'b1;
      data_d = acc_q;
      acc_d  = '0;
      lane_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      lane_q <= '0;
      wr_q   <= 1'b0;
      data_q <= '0;
    end else begin
      acc_q  <= acc_d;
      lane_q <= lane_d;
      wr_q   <= wr_d;
      data_q <= data_d;
    end
  end

  assign fifo_wr   = wr_q;
  assign fifo_data = data_q;

  // R6: a pending partial word is flushed at message end
  assert_flush_partial_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && lane_q != '0) |=> (fifo_wr && lane_q == '0));

  // R7: a one-byte partial word has empty upper lanes
  assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && lane_q == LANE_W'(1)) |=> fifo_data[WORD_W-1:BYTE_BITS] == '0);

  // R2: writes are single-cycle pulses
  assert_single_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |=> !fifo_wr);

  // R10: no write follows a disabled cycle
  assert_abort_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !fifo_wr);
endmodule

// File: rtl/rxp_byte_tally.sv
module rxp_byte_tally #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             byte_stb,
  input  logic             frame_end,
  input  logic             done_clr,
  output logic [CNT_W-1:0] byte_count,
  output logic             rx_done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] cnt_reg_q, cnt_reg_d;
  logic             done_q, done_d;

  always_comb begin
    cnt_d     = cnt_q;
    cnt_reg_d = cnt_reg_q;
    if (!rx_en) begin
      cnt_d = '0;
    end else if (frame_end) begin
      cnt_reg_d = cnt_q;
      cnt_d     = '0;
    end else if (byte_stb) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_comb begin
    done_d = done_q;
    if (rx_en && frame_end)
      done_d = 1'b1;
    else if (done_clr)
      done_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      cnt_reg_q <= '0;
      done_q    <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      cnt_reg_q <= cnt_reg_d;
      done_q    <= done_d;
    end
  end

  assign byte_count = cnt_reg_q;
  assign rx_done    = done_q;

  // R1: each byte steps the running counter by one
  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && byte_stb) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  // R5: message end latches the count, clears the counter, sets done
  assert_end_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (rx_done && byte_count == $past(cnt_q) && cnt_q == '0));

  // R9: done is sticky without a clear
  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !done_clr) |=> rx_done);

  // R9: a clear drops done and keeps the count register
  assert_clear_keeps_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_clr && !frame_end) |=> (!rx_done && $stable(byte_count)));

  // R10: disabled receiver restarts its counter
  assert_abort_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (cnt_q == '0 && $stable(byte_count)));
endmodule

// File: rtl/serial_rx_packer.sv
module serial_rx_packer #(
  parameter int   BYTE_BITS  = 8,
  parameter int   WORD_BYTES = 4,
  parameter int   IDLE_BITS  = 8,
  parameter int   CNT_W      = 16,
  parameter logic IDLE_LEVEL = 1'b1,
  localparam int  WORD_W     = BYTE_BITS * WORD_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              bit_en,
  input  logic              rx_line,
  input  logic              done_clr,
  output logic              fifo_wr,
  output logic [WORD_W-1:0] fifo_data,
  output logic [CNT_W-1:0]  byte_count,
  output logic              rx_done
);
  logic [1:0]           rst_sync_q;
  logic                 rst_int_n;
  logic                 byte_stb;
  logic [BYTE_BITS-1:0] byte_val;
  logic                 frame_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rxp_bit_shifter #(
    .BYTE_BITS (BYTE_BITS),
    .IDLE_BITS (IDLE_BITS),
    .IDLE_LEVEL(IDLE_LEVEL)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rx_en    (rx_en),
    .bit_en   (bit_en),
    .rx_line  (rx_line),
    .byte_stb (byte_stb),
    .byte_val (byte_val),
    .frame_end(frame_end)
  );

  rxp_word_packer #(
    .BYTE_BITS (BYTE_BITS),
    .WORD_BYTES(WORD_BYTES)
  ) u_pack (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rx_en    (rx_en),
    .byte_stb (byte_stb),
    .byte_val (byte_val),
    .frame_end(frame_end),
    .fifo_wr  (fifo_wr),
    .fifo_data(fifo_data)
  );

  rxp_byte_tally #(
    .CNT_W(CNT_W)
  ) u_tally (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rx_en     (rx_en),
    .byte_stb  (byte_stb),
    .frame_end (frame_end),
    .done_clr  (done_clr),
    .byte_count(byte_count),
    .rx_done   (rx_done)
  );

  // R2: a write never appears without an enabled receiver one cycle earlier
  assert_write_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    fifo_wr |-> $past(rx_en));
endmodule

// File: tb/tb_serial_rx_packer.sv
module tb_serial_rx_packer;
  logic        clk;
  logic        rst_n;
  logic        rx_en;
  logic        bit_en;
  logic        rx_line;
  logic        done_clr;
  logic        fifo_wr;
  logic [31:0] fifo_data;
  logic [15:0] byte_count;
  logic        rx_done;

  int checks = 0;
  int errors = 0;
  int got_n  = 0;
  logic [31:0] got [0:1023];
  bit finished = 1'b0;

  serial_rx_packer dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .bit_en(bit_en),
    .rx_line(rx_line), .done_clr(done_clr), .fifo_wr(fifo_wr),
    .fifo_data(fifo_data), .byte_count(byte_count), .rx_done(rx_done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (fifo_wr) begin
      got[got_n[9:0]] = fifo_data;
      got_n = got_n + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input int gap);
    rx_line = b;
    bit_en  = 1'b1;
    @(negedge clk);
    bit_en  = 1'b0;
    rx_line = 1'b1;
    repeat (gap) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v, input int gap);
    for (int i = 0; i < 8; i++) send_bit(v[i], gap);
  endtask

  task automatic send_ones(input int k, input int gap);
    for (int i = 0; i < k; i++) send_bit(1'b1, gap);
  endtask

  // bytes keep bit 0 and bit 3 clear: no run of eight ones can form
  function automatic logic [7:0] gen(input int seed, input int i);
    gen = 8'((seed * 37 + i * 13 + 5) & 8'hF6);
  endfunction

  task automatic clear_done();
    done_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_frame(input int n, input int seed, input int gap, input int pre);
    int base;
    int words;
    logic [15:0] cnt_before;
    base = got_n;
    send_ones(pre, gap);
    for (int i = 0; i < n; i++) send_byte(gen(seed, i), gap);
    send_ones(8, gap);
    repeat (3) @(negedge clk);
    words = (n + 3) / 4;
    chk(byte_count == 16'(n), "R1/R5 byte_count after message", 32'(byte_count), 32'(n));
    chk(rx_done == 1'b1, "R5 rx_done set at end", 32'(rx_done), 32'd1);
    chk(got_n - base == words, "R2/R6 number of FIFO writes", 32'(got_n - base), 32'(words));
    for (int k = 0; k < words; k++) begin
      logic [31:0] w;
      w = '0;
      for (int j = 0; j < 4; j++)
        if (4 * k + j < n) w = w | (32'(gen(seed, 4 * k + j)) << (8 * j));
      chk(got[10'(base + k)] == w, "R3/R7 packed word", got[10'(base + k)], w);
    end
    cnt_before = byte_count;
    clear_done();
    chk(rx_done == 1'b0, "R9 done cleared", 32'(rx_done), 32'd0);
    chk(byte_count == cnt_before, "R9 clear keeps count", 32'(byte_count), 32'(cnt_before));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    rst_n = 1'b0; rx_en = 1'b0; bit_en = 1'b0; rx_line = 1'b1; done_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(fifo_wr == 1'b0, "reset fifo_wr", 32'(fifo_wr), 32'd0);
    chk(rx_done == 1'b0, "reset rx_done", 32'(rx_done), 32'd0);
    chk(byte_count == 16'd0, "reset byte_count", 32'(byte_count), 32'd0);
    chk(fifo_data == 32'd0, "reset fifo_data", fifo_data, 32'd0);

    // R10: line ignored while disabled
    base = got_n;
    send_byte(8'h00, 0);
    send_ones(8, 0);
    repeat (2) @(negedge clk);
    chk(got_n == base, "R10 no write while disabled", 32'(got_n - base), 32'd0);
    chk(rx_done == 1'b0, "R10 no done while disabled", 32'(rx_done), 32'd0);

    rx_en = 1'b1;
    @(negedge clk);

    // R1..R8 sweep over lengths, patterns, strobe spacing and leading idle bits
    for (int gap = 0; gap < 3; gap += 2)
      for (int seed = 1; seed <= 3; seed++)
        for (int n = 1; n <= 12; n++)
          run_frame(n, seed + n, gap, (n % 3) * 3);

    // R4: seven ones do not end a message; they become part of a byte
    base = got_n;
    send_byte(8'h52, 1);
    send_byte(8'h34, 1);
    send_ones(7, 1);
    repeat (2) @(negedge clk);
    chk(rx_done == 1'b0, "R4 seven idle bits do not end", 32'(rx_done), 32'd0);
    send_bit(1'b0, 1);
    send_ones(8, 1);
    repeat (3) @(negedge clk);
    chk(byte_count == 16'd3, "R4 count with 0x7F byte", 32'(byte_count), 32'd3);
    chk(got_n - base == 1, "R4 one partial write", 32'(got_n - base), 32'd1);
    chk(got[10'(base)] == 32'h007F3452, "R4 word with 0x7F byte", got[10'(base)], 32'h007F3452);
    clear_done();

    // R9: end and clear in the same cycle, done ends high
    send_byte(8'h10, 0);
    send_ones(7, 0);
    rx_line = 1'b1; bit_en = 1'b1; done_clr = 1'b1;
    @(negedge clk);
    bit_en = 1'b0; done_clr = 1'b0;
    repeat (2) @(negedge clk);
    chk(rx_done == 1'b1, "R9 set wins over clear", 32'(rx_done), 32'd1);
    chk(byte_count == 16'd1, "R9 count on collision", 32'(byte_count), 32'd1);
    clear_done();

    // R10: abort after five bytes drops the pending byte and restarts the counter
    base = got_n;
    for (int i = 0; i < 5; i++) send_byte(gen(9, i), 0);
    repeat (2) @(negedge clk);
    chk(got_n - base == 1, "R10 full word before abort", 32'(got_n - base), 32'd1);
    rx_en = 1'b0;
    repeat (2) @(negedge clk);
    chk(got_n - base == 1, "R10 no flush on abort", 32'(got_n - base), 32'd1);
    chk(rx_done == 1'b0, "R10 no done on abort", 32'(rx_done), 32'd0);
    chk(byte_count == 16'd1, "R10 count register kept", 32'(byte_count), 32'd1);
    rx_en = 1'b1;
    @(negedge clk);
    base = got_n;
    send_byte(8'h22, 0);
    send_byte(8'h44, 0);
    send_ones(8, 0);
    repeat (3) @(negedge clk);
    chk(byte_count == 16'd2, "R10 counter restarted after abort", 32'(byte_count), 32'd2);
    chk(got[10'(base)] == 32'h00004422, "R10 word after abort", got[10'(base)], 32'h00004422);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule